// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block runs one 8-bit general-purpose I/O port. Software reaches it through a small synchronous register bus with four registers. The pin register reads back the synchronized pad levels, and a write to it lands in the output latch. The latch register reads back the stored output value. The direction register uses 1 for input and 0 for a driven output. The analog-select register clears the digital read of each pin it marks.

In front of each pad a fixed-priority output selector gives the driver to a peripheral when that peripheral asserts its enable. When no peripheral claims the pin, the driver falls back to the latch, gated by the direction bit. The peripherals are:
- a DAC enable on pin 2;
- SR-latch and comparator outputs on pins 4 and 5;
- a clock output on pin 6.

A configuration input hands pins 6 and 7 to an oscillator. While it is set, those two pins are released and their register bits are hidden.

Pad inputs pass through a two-flop synchronizer. Read data, pad outputs and output enables all come from registers, so each one reflects the inputs of the previous clock edge.

Top module: `gpio_mux_port`

## Requirements
- R1: A synchronous active-high reset sets the following: direction = 0xFF, latch = 0x00, analog-select = 0x2F, pad_oe = 0, pad_out = 0, bus_rdata = 0.
- R2: Register addresses are pin = 0, latch = 1, direction = 2, analog-select = 3. With a direction bit at 0, the pin's pad_oe is 1 and pad_out carries the latch bit one cycle after the registers hold those values. With a direction bit at 1, pad_oe is 0.
- R3: A write to address 0 updates the output latch. A read at address 0 returns pad_in after two synchronizer stages, so a pad change at a clock edge appears on bus_rdata three edges later.
- R4: A read at address 1 returns the latch value, whatever the pad levels are. bus_rdata is registered: it shows the register selected by bus_addr at the previous edge.
- R5: The analog-select register stores only bits 5 and 3:0. Bits 7, 6 and 4 always read 0.
- R6: A pin whose analog-select bit is 1 reads 0 at address 0. Its direction bit still controls its driver.
- R7: While osc_claim is 1, bits 7:6 read 0 at addresses 0, 1 and 2, and pad_oe[7:6] is 0 on the following cycle.
- R8: While dac_en is 1, the digital driver of pin 2 is off (pad_oe[2] = 0), whatever its direction bit is.
- R9: On pin 4 the order of control is srq_en, then c1_en, then the direction/latch. An enabled peripheral drives the pin (pad_oe = 1) with its own value.
- R10: On pin 5 the order of control is srnq_en, then c2_en, then the direction/latch.
- R11: On pin 6, clko_en drives clko over the latch, unless osc_claim is set. Peripheral outputs drive in the same order when the pin is in analog mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| osc_claim | input | 1 | Oscillator owns pins 7:6 |
| dac_en | input | 1 | DAC output active on pin 2 |
| srq_en | input | 1 | SR Q output enable, pin 4 |
| srq | input | 1 | SR Q value |
| c1_en | input | 1 | Comparator 1 output enable, pin 4 |
| c1_out | input | 1 | Comparator 1 value |
| srnq_en | input | 1 | SR inverted-Q enable, pin 5 |
| srnq | input | 1 | SR inverted-Q value |
| c2_en | input | 1 | Comparator 2 output enable, pin 5 |
| c2_out | input | 1 | Comparator 2 value |
| clko_en | input | 1 | Clock output enable, pin 6 |
| clko | input | 1 | Clock output value |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |

## Verification
Two things can happen in the same cycle: a bus write to the latch or direction register, and a peripheral enable that takes over a pin. The bench raises SR, comparator and clock enables while it rewrites the latch and direction registers and while the pin is in analog mode. A behavioural reference model applies the priority order to the register values from before the write. It is compared against pad_out, pad_oe and bus_rdata on every cycle, so a wrong ordering or a lost write shows up as a mismatch in that cycle.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  typedef enum logic [1:0] {
    REG_PIN = 2'd0,
    REG_LAT = 2'd1,
    REG_DIR = 2'd2,
    REG_ANA = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic dac_en;
    logic srq_en;
    logic srq;
    logic c1_en;
    logic c1_out;
    logic srnq_en;
    logic srnq;
    logic c2_en;
    logic c2_out;
    logic clko_en;
    logic clko;
  } periph_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_mux_pkg::*;
#(
  parameter int           W        = 8,
  parameter int           OSC_PINS = 2,
  parameter logic [W-1:0] ANA_MASK = 8'h2F,
  parameter logic [W-1:0] ANA_RST  = 8'h2F
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   bus_addr,
  input  logic         bus_we,
  input  logic [W-1:0] bus_wdata,
  input  logic         osc_claim,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] bus_rdata,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] dir_q
);
  localparam logic [W-1:0] OSC_MASK = ~({W{1'b1}} >> OSC_PINS);

  logic [W-1:0] ana_q;
  logic [W-1:0] vis;

  assign vis = osc_claim ? ~OSC_MASK : {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q     <= '0;
      dir_q     <= '1;
      ana_q     <= ANA_RST & ANA_MASK;
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        REG_PIN: bus_rdata <= pin_sync & ~ana_q & vis;
        REG_LAT: bus_rdata <= lat_q & vis;
        REG_DIR: bus_rdata <= dir_q & vis;
        default: bus_rdata <= ana_q;
      endcase
      if (bus_we) begin
        case (bus_addr)
          REG_PIN, REG_LAT: lat_q <= bus_wdata;
          REG_DIR:          dir_q <= bus_wdata;
          default:          ana_q <= bus_wdata & ANA_MASK;
        endcase
      end
    end
  end

  p_ana_unimpl_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == REG_ANA) |=> ((bus_rdata & ~ANA_MASK) == '0));

  p_analog_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == REG_PIN) |=> ((bus_rdata & $past(ana_q)) == '0));

  p_osc_hide_r7: assert property (@(posedge clk) disable iff (rst)
    (osc_claim && bus_addr != REG_ANA) |=> ((bus_rdata & OSC_MASK) == '0));
endmodule

// File: rtl/gpio_out_mux.sv
module gpio_out_mux
  import gpio_mux_pkg::*;
#(
  parameter int W        = 8,
  parameter int OSC_PINS = 2,
  parameter int DAC_PIN  = 2,
  parameter int SR_PIN   = 4,
  parameter int SRN_PIN  = 5,
  parameter int CLK_PIN  = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lat_q,
  input  logic [W-1:0] dir_q,
  input  logic         osc_claim,
  input  periph_t      periph,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  localparam logic [W-1:0] OSC_MASK = ~({W{1'b1}} >> OSC_PINS);

  logic [W-1:0] sel_out, sel_oe;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic o, e;
    if (i == DAC_PIN) begin : g_dac
      assign e = periph.dac_en ? 1'b0 : ~dir_q[i];
      assign o = periph.dac_en ? 1'b0 : lat_q[i];
    end else if (i == SR_PIN) begin : g_sr
      assign e = periph.srq_en | periph.c1_en | ~dir_q[i];
      assign o = periph.srq_en ? periph.srq :
                 periph.c1_en  ? periph.c1_out : lat_q[i];
    end else if (i == SRN_PIN) begin : g_srn
      assign e = periph.srnq_en | periph.c2_en | ~dir_q[i];
      assign o = periph.srnq_en ? periph.srnq :
                 periph.c2_en   ? periph.c2_out : lat_q[i];
    end else if (i == CLK_PIN) begin : g_clk
      assign e = periph.clko_en | ~dir_q[i];
      assign o = periph.clko_en ? periph.clko : lat_q[i];
    end else begin : g_plain
      assign e = ~dir_q[i];
      assign o = lat_q[i];
    end
    assign sel_oe[i]  = (osc_claim && OSC_MASK[i]) ? 1'b0 : e;
    assign sel_out[i] = (osc_claim && OSC_MASK[i]) ? 1'b0 : o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_out <= sel_out;
      pad_oe  <= sel_oe;
    end
  end

  p_osc_release_r7: assert property (@(posedge clk) disable iff (rst)
    osc_claim |=> ((pad_oe & OSC_MASK) == '0));

  p_dac_off_r8: assert property (@(posedge clk) disable iff (rst)
    periph.dac_en |=> !pad_oe[DAC_PIN]);

  p_srq_wins_r9: assert property (@(posedge clk) disable iff (rst)
    periph.srq_en |=> (pad_oe[SR_PIN] && pad_out[SR_PIN] == $past(periph.srq)));

  p_srnq_wins_r10: assert property (@(posedge clk) disable iff (rst)
    periph.srnq_en |=> (pad_oe[SRN_PIN] && pad_out[SRN_PIN] == $past(periph.srnq)));

  p_clko_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (periph.clko_en && !osc_claim) |=> (pad_oe[CLK_PIN] && pad_out[CLK_PIN] == $past(periph.clko)));
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int          W           = 8,
  parameter int          SYNC_STAGES = 2,
  parameter int          OSC_PINS    = 2,
  parameter logic [7:0]  ANA_MASK    = 8'h2F,
  parameter logic [7:0]  ANA_RST     = 8'h2F
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       osc_claim,
  input  logic       dac_en,
  input  logic       srq_en,
  input  logic       srq,
  input  logic       c1_en,
  input  logic       c1_out,
  input  logic       srnq_en,
  input  logic       srnq,
  input  logic       c2_en,
  input  logic       c2_out,
  input  logic       clko_en,
  input  logic       clko,
  input  logic [7:0] pad_in,
  output logic [7:0] pad_out,
  output logic [7:0] pad_oe
);
  logic [W-1:0] pin_sync, lat_q, dir_q;
  periph_t      periph;

  assign periph = '{dac_en: dac_en, srq_en: srq_en, srq: srq, c1_en: c1_en,
                    c1_out: c1_out, srnq_en: srnq_en, srnq: srnq, c2_en: c2_en,
                    c2_out: c2_out, clko_en: clko_en, clko: clko};

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync)
  );

  gpio_regs #(.W(W), .OSC_PINS(OSC_PINS), .ANA_MASK(ANA_MASK), .ANA_RST(ANA_RST)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .osc_claim(osc_claim), .pin_sync(pin_sync),
    .bus_rdata(bus_rdata), .lat_q(lat_q), .dir_q(dir_q)
  );

  gpio_out_mux #(.W(W), .OSC_PINS(OSC_PINS)) u_mux (
    .clk(clk), .rst(rst), .lat_q(lat_q), .dir_q(dir_q),
    .osc_claim(osc_claim), .periph(periph),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && bus_rdata == '0));

  p_input_dir_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == REG_DIR && bus_wdata == 8'hFF && !srq_en && !c1_en
     && !srnq_en && !c2_en && !clko_en) ##1 (!srq_en && !c1_en && !srnq_en
     && !c2_en && !clko_en) |=> (pad_oe == '0));
endmodule

// File: tb/gpio_mux_port_bench.sv
module gpio_mux_port_bench;
  logic       clk = 0;
  logic       rst = 1;
  logic [1:0] addr = 0;
  logic       we = 0;
  logic [7:0] wdata = 0;
  logic       osc = 0, dac = 0, srq_en = 0, srq = 0, c1_en = 0, c1 = 0;
  logic       srnq_en = 0, srnq = 0, c2_en = 0, c2 = 0, clko_en = 0, clko = 0;
  logic [7:0] pad_in = 0;
  wire  [7:0] rdata, pad_out, pad_oe;

  int checks = 0, failures = 0, cyc = 0;
  bit started = 0;
  string tag = "R1";

  logic [7:0] m_lat = 0, m_dir = 8'hFF, m_ana = 8'h2F, s1 = 0, s2 = 0;
  logic [7:0] m_rd = 0, m_out = 0, m_oe = 0, vis;

  always #2.5 clk = ~clk;

  gpio_mux_port u_gpio_mux_port (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .osc_claim(osc), .dac_en(dac), .srq_en(srq_en), .srq(srq),
    .c1_en(c1_en), .c1_out(c1), .srnq_en(srnq_en), .srnq(srnq), .c2_en(c2_en),
    .c2_out(c2), .clko_en(clko_en), .clko(clko), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // Behavioural reference: all right-hand values are pre-edge values.
  always @(posedge clk) begin
    started = 1;
    cyc++;
    if (rst) begin
      m_lat = 0; m_dir = 8'hFF; m_ana = 8'h2F; s1 = 0; s2 = 0;
      m_rd = 0; m_out = 0; m_oe = 0;
    end else begin
      vis = osc ? 8'h3F : 8'hFF;
      case (addr)
        2'd0: m_rd = s2 & ~m_ana & vis;
        2'd1: m_rd = m_lat & vis;
        2'd2: m_rd = m_dir & vis;
        default: m_rd = m_ana;
      endcase
      for (int i = 0; i < 8; i++) begin
        logic o, e;
        o = m_lat[i]; e = !m_dir[i];
        if (i == 2 && dac) begin o = 0; e = 0; end
        if (i == 4) begin
          if (srq_en) begin o = srq; e = 1; end
          else if (c1_en) begin o = c1; e = 1; end
        end
        if (i == 5) begin
          if (srnq_en) begin o = srnq; e = 1; end
          else if (c2_en) begin o = c2; e = 1; end
        end
        if (i == 6 && clko_en) begin o = clko; e = 1; end
        if (i >= 6 && osc) begin o = 0; e = 0; end
        m_out[i] = o; m_oe[i] = e;
      end
      if (we) begin
        case (addr)
          2'd0, 2'd1: m_lat = wdata;
          2'd2: m_dir = wdata;
          default: m_ana = wdata & 8'h2F;
        endcase
      end
      s2 = s1; s1 = pad_in;
    end
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog: actual cycles=%0d expected below 20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cmp(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (started) begin
    cmp("bus_rdata", rdata, m_rd);
    cmp("pad_out", pad_out, m_out);
    cmp("pad_oe", pad_oe, m_oe);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1; step(1); we = 0;
  endtask

  task automatic rd(logic [1:0] a, int n);
    addr = a; step(n);
  endtask

  initial begin
    step(3);
    rst = 0;
    tag = "R1"; step(2);
    tag = "R2"; wr(2'd1, 8'hA5); wr(2'd2, 8'h00); step(2);
    wr(2'd2, 8'hF0); step(2); wr(2'd2, 8'hFF); step(2);
    tag = "R3"; wr(2'd3, 8'h00); wr(2'd0, 8'h3C); pad_in = 8'h96; rd(2'd0, 4);
    pad_in = 8'h69; rd(2'd0, 4);
    tag = "R4"; pad_in = 8'hFF; rd(2'd1, 3); pad_in = 8'h00; rd(2'd1, 2);
    tag = "R5"; wr(2'd3, 8'hFF); rd(2'd3, 2); wr(2'd3, 8'hD0); rd(2'd3, 2);
    tag = "R6"; wr(2'd3, 8'h2F); pad_in = 8'hFF; rd(2'd0, 4);
    wr(2'd2, 8'hFE); rd(2'd0, 2); wr(2'd2, 8'hFF);
    tag = "R7"; wr(2'd2, 8'h00); wr(2'd1, 8'hFF); osc = 1;
    rd(2'd0, 2); rd(2'd1, 2); rd(2'd2, 2); rd(2'd3, 2);
    wr(2'd1, 8'h40); step(1); osc = 0; step(2);
    tag = "R8"; wr(2'd1, 8'h04); dac = 1; step(2); wr(2'd2, 8'h00); dac = 0; step(2);
    tag = "R9"; wr(2'd3, 8'h2F); wr(2'd1, 8'h00);
    c1_en = 1; c1 = 1; step(2); srq_en = 1; srq = 0; wr(2'd1, 8'hFF); step(1);
    srq = 1; c1 = 0; step(2); srq_en = 0; step(2); c1_en = 0; wr(2'd2, 8'hFF); step(2);
    tag = "R10"; c2_en = 1; c2 = 1; step(2); srnq_en = 1; srnq = 0; step(2);
    srnq_en = 0; c2 = 0; step(2); c2_en = 0; step(2);
    tag = "R11"; clko_en = 1;
    for (int k = 0; k < 6; k++) begin clko = ~clko; step(1); end
    osc = 1; step(2); osc = 0; wr(2'd2, 8'h00); clko_en = 0; step(2);
    wr(2'd0, 8'h55); step(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule